// File: doc/BRIEF.md
# Write-Completion Status Responder

This block sits on the read return path of a byte-wide non-volatile memory model. While the memory's self-timed internal programming cycle runs, the cells cannot be read. Instead of returning array data, the block sends back a status word. The host can then find out when programming has finished by reading, without an interrupt line. Two detection methods work side by side. The top data bit returns the inverse of the most recently written byte's top bit. The next bit changes value on every completed read. When programming is over, reads again return array contents without change.

The block is combinational from the read strobes to the bus, apart from a small amount of state:
- a one-bit access tracker, which marks a read that has begun and not yet ended, together with a flag recording whether that read saw a live programming cycle;
- the toggle flip-flop.

The toggle advances only when a read ends. This keeps the value stable for the whole of a long access. If a write was refused because the memory was write-protected, the status substitution is suppressed and reads return normal data.

Top module: `wcs_status_responder`

## Requirements
- R1: `bus_oe` is 1 exactly when `chip_sel_n` and `out_en_n` are both 0; whenever `bus_oe` is 0, `bus_out` is all zeros.
- R2: During a read with `prog_busy` low, `bus_out` equals `arr_data`.
- R3: During a read with `prog_busy` high and `write_rejected` low at `rd_addr == last_addr`, bit 7 of `bus_out` is the inverse of bit 7 of `last_data`.
- R4: In the case of R3, bits 5 down to 0 of `bus_out` equal bits 5 down to 0 of `last_data`.
- R5: Over consecutive reads made while programming is live, bit 6 of `bus_out` takes opposite values on each pair of neighbouring reads.
- R6: Within a single read held for several cycles, bit 6 does not change; one access advances the toggle at most once, when the access ends.
- R7: Reads made with `prog_busy` low do not advance the toggle: a live read after any number of idle-state reads shows the inverse of bit 6 from the last live read.
- R8: With `write_rejected` high, reads return `arr_data` even while `prog_busy` is high, and they do not advance the toggle.
- R9: With `POLL_ANY_ADDR` = 0, a live read at an address other than `last_addr` returns `arr_data` on bits 7 and 5..0, and the toggle on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Device select, active low |
| out_en_n | input | 1 | Read output enable, active low |
| prog_busy | input | 1 | Internal programming cycle in progress |
| write_rejected | input | 1 | Last write was refused by protection; suppresses status |
| rd_addr | input | ADDR_W | Address of the current read |
| last_addr | input | ADDR_W | Address of the most recent accepted write |
| last_data | input | DATA_W | Data of the most recent accepted write |
| arr_data | input | DATA_W | Array contents at `rd_addr` |
| bus_out | output | DATA_W | Data returned on the bus |
| bus_oe | output | 1 | Bus drive enable (tri-state control) |

## Verification
The hardest situation to reach is a toggle that may have advanced when it should not. The toggle's starting value is unspecified and cannot be read directly, so any wrong advance shows up only as a parity error several reads later. The stimulus therefore brackets each suspect sequence between two live reads: a held multi-cycle access, a run of reads with programming idle, or reads after a refused write. The second live read must show exactly one inversion relative to the first. A vector table covers the data selection cases, with bit 6 masked wherever its absolute value is unknown.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  // Source selected for the returned byte.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_SPLIT  = 2'd3
  } src_e;

  // Read access tracking state.
  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_OPEN = 1'b1
  } acc_e;
endpackage

// File: rtl/wcs_rst_sync.sv
module wcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[STAGES-1];
endmodule

// File: rtl/wcs_access_track.sv
module wcs_access_track
  import wcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_active,
  input  logic poll_live,
  output logic advance
);
  acc_e st_q, st_d;
  logic seen_q, seen_d;
  logic upd_en;

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    unique case (st_q)
      ACC_IDLE: begin
        if (rd_active) begin
          st_d   = ACC_OPEN;
          seen_d = poll_live;
        end
      end
      ACC_OPEN: begin
        if (rd_active) begin
          seen_d = seen_q | poll_live;
        end else begin
          st_d   = ACC_IDLE;
          seen_d = 1'b0;
        end
      end
      default: begin
        st_d   = ACC_IDLE;
        seen_d = 1'b0;
      end
    endcase
  end

  assign upd_en = rd_active | (st_q == ACC_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ACC_IDLE;
      seen_q <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  // One pulse at the end of an access that saw a live programming cycle.
  assign advance = (st_q == ACC_OPEN) & ~rd_active & seen_q;
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic tog
);
  logic tog_q, tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (advance) tog_q <= tog_d;
  end

  assign tog = tog_q;
endmodule

// File: rtl/wcs_out_mux.sv
module wcs_out_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter bit POLL_ANY_ADDR = 1'b0
) (
  input  logic              rd_active,
  input  logic              poll_live,
  input  logic              addr_hit,
  input  logic              tog,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] bus_out
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  src_e src;
  logic status_sel;

  generate
    if (POLL_ANY_ADDR) begin : g_any
      assign status_sel = poll_live;
    end else begin : g_hit
      assign status_sel = poll_live & addr_hit;
    end
  endgenerate

  always_comb begin
    if (!rd_active)      src = SRC_NONE;
    else if (!poll_live) src = SRC_ARRAY;
    else if (status_sel) src = SRC_STATUS;
    else                 src = SRC_SPLIT;
  end

  always_comb begin
    unique case (src)
      SRC_NONE:   bus_out = '0;
      SRC_ARRAY:  bus_out = arr_data;
      SRC_STATUS: bus_out = {~last_data[POLL_BIT], tog, last_data[TOG_BIT-1:0]};
      SRC_SPLIT:  bus_out = {arr_data[POLL_BIT], tog, arr_data[TOG_BIT-1:0]};
      default:    bus_out = '0;
    endcase
  end
endmodule

// File: rtl/wcs_status_responder.sv
module wcs_status_responder #(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 17,
  parameter bit POLL_ANY_ADDR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              prog_busy,
  input  logic              write_rejected,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic srst_n;
  logic rd_active;
  logic poll_live;
  logic addr_hit;
  logic advance;
  logic tog;

  assign rd_active = ~chip_sel_n & ~out_en_n;
  assign poll_live = prog_busy & ~write_rejected;
  assign addr_hit  = (rd_addr == last_addr);
  assign bus_oe    = rd_active;

  wcs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wcs_access_track u_trk (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_active (rd_active),
    .poll_live (poll_live),
    .advance   (advance)
  );

  wcs_toggle u_tog (
    .clk     (clk),
    .rst_n   (srst_n),
    .advance (advance),
    .tog     (tog)
  );

  wcs_out_mux #(
    .DATA_W        (DATA_W),
    .POLL_ANY_ADDR (POLL_ANY_ADDR)
  ) u_mux (
    .rd_active (rd_active),
    .poll_live (poll_live),
    .addr_hit  (addr_hit),
    .tog       (tog),
    .last_data (last_data),
    .arr_data  (arr_data),
    .bus_out   (bus_out)
  );
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_sel_n,
  input logic              out_en_n,
  input logic              prog_busy,
  input logic              write_rejected,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe
);
  logic valid_q;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign live = prog_busy & ~write_rejected;

  // R1: an undriven bus carries zeros
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe) |-> (bus_out == '0));

  // R2: idle programming returns the array unchanged
  assert_array_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !prog_busy) |-> (bus_out == arr_data));

  // R3: inverted top bit on the last written location
  assert_poll_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && live && rd_addr == last_addr) |->
      (bus_out[DATA_W-1] != last_data[DATA_W-1]));

  // R4: low field echoes the last written byte
  assert_low_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && live && rd_addr == last_addr) |->
      (bus_out[DATA_W-3:0] == last_data[DATA_W-3:0]));

  // R6: bit 6 holds for the whole of one access
  assert_tog_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(bus_oe) && bus_oe && $past(live) && live) |->
      $stable(bus_out[DATA_W-2]));

  // R8: a refused write disables substitution
  assert_reject_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && write_rejected) |-> (bus_out == arr_data));
endmodule

bind wcs_status_responder wcs_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_wcs_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .chip_sel_n     (chip_sel_n),
  .out_en_n       (out_en_n),
  .prog_busy      (prog_busy),
  .write_rejected (write_rejected),
  .rd_addr        (rd_addr),
  .last_addr      (last_addr),
  .last_data      (last_data),
  .arr_data       (arr_data),
  .bus_out        (bus_out),
  .bus_oe         (bus_oe)
);

// File: tb/test_wcs_status_responder.sv
`timescale 1ns/1ps
module test_wcs_status_responder;
  localparam int DW = 8;
  localparam int AW = 17;
  localparam logic [AW-1:0] LADDR = 17'h05A3C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chip_sel_n, out_en_n, prog_busy, write_rejected;
  logic [AW-1:0] rd_addr, last_addr;
  logic [DW-1:0] last_data, arr_data;
  logic [DW-1:0] bus_out;
  logic          bus_oe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wcs_status_responder #(.DATA_W(DW), .ADDR_W(AW), .POLL_ANY_ADDR(1'b0)) i_wcs_status_responder (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .prog_busy(prog_busy), .write_rejected(write_rejected), .rd_addr(rd_addr),
    .last_addr(last_addr), .last_data(last_data), .arr_data(arr_data),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  typedef struct packed {
    logic          cs_n;
    logic          oe_n;
    logic          busy;
    logic          rej;
    logic          hit;
    logic [DW-1:0] ld;
    logic [DW-1:0] arr;
    logic          exp_oe;
    logic [DW-1:0] exp;
    logic [DW-1:0] mask;
  } vec_t;

  // Bit 6 is masked where the toggle's absolute value is unknown.
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hA5, 1'b0, 8'h00, 8'hFF}, // R1
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 8'hA5, 1'b0, 8'h00, 8'hFF}, // R1
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hA5, 1'b1, 8'hA5, 8'hFF}, // R2
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 8'hA5, 1'b1, 8'hBC, 8'hBF}, // R3 R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC5, 8'h00, 1'b1, 8'h05, 8'hBF}, // R3 R4
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h5A, 1'b1, 8'h5A, 8'hFF}, // R8
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h81, 1'b1, 8'h81, 8'hBF}, // R9
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h7E, 1'b1, 8'h7E, 8'hFF}  // R2
  };

  function automatic string vec_req(input int idx);
    case (idx)
      0, 1:    return "R1";
      2, 7:    return "R2";
      3, 4:    return "R3/R4";
      5:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input logic [DW-1:0] mask);
    checks++;
    if (((act ^ exp) & mask) != '0) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, mask);
    end
  endtask

  task automatic read_begin(input logic busy, input logic rej, input logic hit,
                            input logic [DW-1:0] ld, input logic [DW-1:0] arr);
    @(negedge clk);
    prog_busy      = busy;
    write_rejected = rej;
    rd_addr        = hit ? LADDR : (LADDR ^ 17'h00001);
    last_data      = ld;
    arr_data       = arr;
    chip_sel_n     = 1'b0;
    out_en_n       = 1'b0;
    #1;
  endtask

  task automatic read_end();
    @(negedge clk);
    chip_sel_n = 1'b1;
    out_en_n   = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic t0, t1, prev;
    rst_n = 1'b0; chip_sel_n = 1'b1; out_en_n = 1'b1; prog_busy = 1'b0;
    write_rejected = 1'b0; rd_addr = LADDR; last_addr = LADDR;
    last_data = 8'h00; arr_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset oe", {7'd0, bus_oe}, 8'h00, 8'hFF);
    check("R1 reset data", bus_out, 8'h00, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Table of data selection cases
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      prog_busy      = VEC[i].busy;
      write_rejected = VEC[i].rej;
      rd_addr        = VEC[i].hit ? LADDR : (LADDR ^ 17'h00001);
      last_data      = VEC[i].ld;
      arr_data       = VEC[i].arr;
      chip_sel_n     = VEC[i].cs_n;
      out_en_n       = VEC[i].oe_n;
      #1;
      check({vec_req(i), " oe"}, {7'd0, bus_oe}, {7'd0, VEC[i].exp_oe}, 8'hFF);
      check(vec_req(i), bus_out, VEC[i].exp, VEC[i].mask);
      read_end();
    end

    // R5: alternation over consecutive live reads
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    prev = bus_out[6];
    read_end();
    for (int k = 0; k < 3; k++) begin
      read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
      check("R5", {7'd0, bus_out[6]}, {7'd0, ~prev}, 8'hFF);
      prev = bus_out[6];
      read_end();
    end

    // R6: held access keeps bit 6, then one advance only
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    t0 = bus_out[6];
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R6 hold", {7'd0, bus_out[6]}, {7'd0, t0}, 8'hFF);
    end
    read_end();
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    check("R6 single advance", {7'd0, bus_out[6]}, {7'd0, ~t0}, 8'hFF);
    read_end();

    // R7: idle-state reads leave the toggle alone
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    t0 = bus_out[6];
    read_end();
    for (int k = 0; k < 3; k++) begin
      read_begin(1'b0, 1'b0, 1'b1, 8'h3C, (k[0] ? 8'h40 : 8'h13));
      check("R7 idle read", bus_out, (k[0] ? 8'h40 : 8'h13), 8'hFF);
      read_end();
    end
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    check("R7 no advance", {7'd0, bus_out[6]}, {7'd0, ~t0}, 8'hFF);
    read_end();

    // R8: refused write reads neither substitute nor advance
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    t1 = bus_out[6];
    read_end();
    for (int k = 0; k < 2; k++) begin
      read_begin(1'b1, 1'b1, 1'b1, 8'h3C, 8'hC3);
      check("R8 array data", bus_out, 8'hC3, 8'hFF);
      read_end();
    end
    read_begin(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00);
    check("R8 no advance", {7'd0, bus_out[6]}, {7'd0, ~t1}, 8'hFF);
    read_end();

    // R9: miss address mixes array bits with the toggle
    read_begin(1'b1, 1'b0, 1'b0, 8'hFF, 8'h2A);
    t0 = bus_out[6];
    check("R9 miss", bus_out, 8'h2A, 8'hBF);
    read_end();
    read_begin(1'b1, 1'b0, 1'b0, 8'hFF, 8'h2A);
    check("R9 miss toggle", {7'd0, bus_out[6]}, {7'd0, ~t0}, 8'hFF);
    read_end();

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule